// File: doc/BRIEF.md
# Bus Ownership Arbiter with Power-On Access Holdoff

This block is the control core of the owner of an external memory bus. It decides, one bus cycle at a time, whether the bus carries an internal access or an SDRAM refresh, or whether it is handed to a single external master through a request/acknowledge handshake. A refresh timer tick marks a refresh as due. If the external master holds the bus when a refresh comes due, the block raises a refresh-out signal so that the master gives the bus back. The refresh then runs before anything else.

The two resets act differently. Power-on reset is asynchronous and silences every output at once, whatever cycle is in progress. It also clears all state, including a 7-bit holdoff counter that must climb to 0x7F before the first internal access is granted. Manual reset is sampled on the clock. It lets the current cycle finish and then parks the block in an access-wait state. In that state accesses and the external master are refused, but refreshes still run. The holdoff counter is untouched by manual reset and saturates, so accesses are never held off a second time.

States: `ST_IDLE` (bus owned, idle), `ST_ACCESS` (internal access cycle), `ST_REFRESH` (refresh cycle), `ST_RELEASED` (external master owns the bus), `ST_MWAIT` (manual-reset access-wait). Transitions:
- From `ST_IDLE`, by priority: a pending refresh goes to `ST_REFRESH`; otherwise manual reset goes to `ST_MWAIT`; otherwise a bus request goes to `ST_RELEASED`; otherwise an access request with the holdoff finished goes to `ST_ACCESS`.
- `ST_ACCESS` and `ST_REFRESH` return to `ST_IDLE` on `cyc_done`.
- `ST_RELEASED` returns to `ST_IDLE` when `ext_req` is sampled low.
- `ST_MWAIT` goes to `ST_REFRESH` on a pending refresh, and to `ST_IDLE` once manual reset is sampled low.

Top module: `bus_own_ctrl`

## Requirements
- R1: While `por_n` is low, all five outputs are 0 at once, with no clock edge needed, even in the middle of an access. After release the block is idle with no refresh pending.
- R2: After `por_n` rises, `acc_gnt` stays 0 for the first 127 rising clock edges, even with `acc_req` held high. It rises on the 128th edge.
- R3: The holdoff counter saturates at 0x7F. After any length of idle time, an access request in `ST_IDLE` is granted on the next edge.
- R4: Manual reset does not clear the holdoff counter. Once manual reset is removed, an access is granted on the next edge from `ST_IDLE`, with no new holdoff.
- R5: A manual reset sampled during an access lets that cycle run until `cyc_done`. Afterwards, while manual reset stays high, `acc_gnt` and `ext_ack` stay 0.
- R6: While manual reset is high, a refresh timer tick still leads to a refresh cycle (`rfsh_go`=1, `bus_oe`=1).
- R7: `ext_ack` rises only from `ST_IDLE`, never together with `bus_oe`, and never in the middle of an access. It stays high while `ext_req` is high and falls on the first edge at which `ext_req` is sampled low.
- R8: `rfsh_out` is 1 exactly while the external master owns the bus and a refresh is pending.
- R9: When the bus comes back with a refresh pending, the first cycle run is a refresh, even if an access request is waiting.
- R10: In `ST_IDLE` the priority is refresh, then manual reset, then bus request, then access. `bus_oe` is 1 during access and refresh cycles. `acc_gnt` is 1 in `ST_ACCESS` and `rfsh_go` is 1 in `ST_REFRESH`, each until the edge at which `cyc_done` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst | input | 1 | Manual reset, synchronous, active high |
| ext_req | input | 1 | Bus request from the external master |
| acc_req | input | 1 | Internal access request |
| rfsh_tick | input | 1 | One-cycle pulse from the refresh timer |
| cyc_done | input | 1 | The current access or refresh cycle ends this clock |
| ext_ack | output | 1 | Bus handed to the external master |
| rfsh_out | output | 1 | Refresh due; asks the external master to give the bus back |
| bus_oe | output | 1 | Bus output enables on |
| acc_gnt | output | 1 | Internal access cycle in progress |
| rfsh_go | output | 1 | Refresh cycle in progress |

## Verification
A state register stuck in or skipping `ST_MWAIT` shows within one edge: an access is granted or a bus request is acknowledged while manual reset is high. A lost pending-refresh flag shows as `rfsh_out` missing while the bus is released, or as an access winning the first cycle after the bus returns. A holdoff counter that is wrongly cleared or starts wrongly moves the first grant away from edge 128, or makes a grant late after a manual reset or a long idle spell.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ACCESS   = 3'd1,
        ST_REFRESH  = 3'd2,
        ST_RELEASED = 3'd3,
        ST_MWAIT    = 3'd4
    } own_state_e;

endpackage

// File: rtl/rst_wait_cnt.sv
module rst_wait_cnt #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             por_n,
    output logic [WIDTH-1:0] cnt,
    output logic             done
);
    localparam logic [WIDTH-1:0] LIMIT = {WIDTH{1'b1}};

    assign done = (cnt == LIMIT);

    // Cleared only by power-on reset; saturates at LIMIT.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_pend.sv
module rfsh_pend (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic take,
    output logic pend
);
    // A tick in the same clock as a take keeps the flag set.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pend <= 1'b0;
        end else begin
            pend <= tick | (pend & ~take);
        end
    end
endmodule

// File: rtl/own_fsm.sv
module own_fsm
    import bus_own_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       mrst,
    input  logic       ext_req,
    input  logic       acc_req,
    input  logic       cyc_done,
    input  logic       wait_done,
    input  logic       pend,
    output own_state_e state,
    output logic       take,
    output logic       ext_ack,
    output logic       rfsh_out,
    output logic       bus_oe,
    output logic       acc_gnt,
    output logic       rfsh_go
);
    own_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (pend)                        nxt = ST_REFRESH;
                else if (mrst)                   nxt = ST_MWAIT;
                else if (ext_req)                nxt = ST_RELEASED;
                else if (acc_req && wait_done)   nxt = ST_ACCESS;
            end
            ST_ACCESS:   if (cyc_done) nxt = ST_IDLE;
            ST_REFRESH:  if (cyc_done) nxt = ST_IDLE;
            ST_RELEASED: if (!ext_req) nxt = ST_IDLE;
            ST_MWAIT: begin
                if (pend)       nxt = ST_REFRESH;
                else if (!mrst) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign take = (nxt == ST_REFRESH) && (state != ST_REFRESH);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        ext_ack  = 1'b0;
        rfsh_out = 1'b0;
        bus_oe   = 1'b0;
        acc_gnt  = 1'b0;
        rfsh_go  = 1'b0;
        unique case (state)
            ST_IDLE, ST_MWAIT: ;
            ST_ACCESS: begin
                bus_oe  = 1'b1;
                acc_gnt = 1'b1;
            end
            ST_REFRESH: begin
                bus_oe  = 1'b1;
                rfsh_go = 1'b1;
            end
            ST_RELEASED: begin
                ext_ack  = 1'b1;
                rfsh_out = pend;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
    import bus_own_pkg::*;
#(
    parameter int WAIT_W = 7
) (
    input  logic clk,
    input  logic por_n,
    input  logic mrst,
    input  logic ext_req,
    input  logic acc_req,
    input  logic rfsh_tick,
    input  logic cyc_done,
    output logic ext_ack,
    output logic rfsh_out,
    output logic bus_oe,
    output logic acc_gnt,
    output logic rfsh_go
);
    logic [WAIT_W-1:0] wait_cnt;
    logic              wait_done;
    logic              pend;
    logic              take;
    own_state_e        state;

    rst_wait_cnt #(.WIDTH(WAIT_W)) i_wait (
        .clk   (clk),
        .por_n (por_n),
        .cnt   (wait_cnt),
        .done  (wait_done)
    );

    rfsh_pend i_pend (
        .clk   (clk),
        .por_n (por_n),
        .tick  (rfsh_tick),
        .take  (take),
        .pend  (pend)
    );

    own_fsm i_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .mrst      (mrst),
        .ext_req   (ext_req),
        .acc_req   (acc_req),
        .cyc_done  (cyc_done),
        .wait_done (wait_done),
        .pend      (pend),
        .state     (state),
        .take      (take),
        .ext_ack   (ext_ack),
        .rfsh_out  (rfsh_out),
        .bus_oe    (bus_oe),
        .acc_gnt   (acc_gnt),
        .rfsh_go   (rfsh_go)
    );
endmodule

// File: rtl/bus_own_chk.sv
module bus_own_chk #(
    parameter int WAIT_W = 7
) (
    input logic              clk,
    input logic              por_n,
    input logic              mrst,
    input logic              ext_req,
    input logic              ext_ack,
    input logic              rfsh_out,
    input logic              bus_oe,
    input logic              acc_gnt,
    input logic              rfsh_go,
    input logic              pend,
    input logic [WAIT_W-1:0] wait_cnt
);
    localparam logic [WAIT_W-1:0] TOP = {WAIT_W{1'b1}};

    a_r1_por_quiet: assert property (@(posedge clk)
        !por_n |-> !(ext_ack || rfsh_out || bus_oe || acc_gnt || rfsh_go));

    a_r2_no_early_grant: assert property (@(posedge clk) disable iff (!por_n)
        $rose(acc_gnt) |-> ($past(wait_cnt) == TOP));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!por_n)
        (wait_cnt == TOP) |=> (wait_cnt == TOP));

    a_r5_no_ack_in_mrst: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ext_ack) |-> !$past(mrst));

    a_r7_ack_oe_apart: assert property (@(posedge clk) disable iff (!por_n)
        !(ext_ack && bus_oe));

    a_r7_hold_ack: assert property (@(posedge clk) disable iff (!por_n)
        (ext_ack && ext_req) |=> ext_ack);

    a_r8_rout_owner: assert property (@(posedge clk) disable iff (!por_n)
        rfsh_out |-> (ext_ack && pend));

    a_r10_one_cycle_kind: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({acc_gnt, rfsh_go, ext_ack}));
endmodule

bind bus_own_ctrl bus_own_chk #(.WAIT_W(WAIT_W)) i_chk (
    .clk      (clk),
    .por_n    (por_n),
    .mrst     (mrst),
    .ext_req  (ext_req),
    .ext_ack  (ext_ack),
    .rfsh_out (rfsh_out),
    .bus_oe   (bus_oe),
    .acc_gnt  (acc_gnt),
    .rfsh_go  (rfsh_go),
    .pend     (pend),
    .wait_cnt (wait_cnt)
);

// File: tb/test_bus_own_ctrl.sv
module test_bus_own_ctrl;
    logic clk = 1'b0;
    logic por_n = 1'b1;
    logic mrst = 1'b0, ext_req = 1'b0, acc_req = 1'b0, rfsh_tick = 1'b0, cyc_done = 1'b0;
    logic ext_ack, rfsh_out, bus_oe, acc_gnt, rfsh_go;
    int   n_chk = 0, n_bad = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    bus_own_ctrl i_bus_own_ctrl (
        .clk(clk), .por_n(por_n), .mrst(mrst), .ext_req(ext_req),
        .acc_req(acc_req), .rfsh_tick(rfsh_tick), .cyc_done(cyc_done),
        .ext_ack(ext_ack), .rfsh_out(rfsh_out), .bus_oe(bus_oe),
        .acc_gnt(acc_gnt), .rfsh_go(rfsh_go)
    );

    // inputs {mrst, ext_req, acc_req, rfsh_tick, cyc_done},
    // expected after the edge {ext_ack, rfsh_out, bus_oe, acc_gnt, rfsh_go}
    localparam int NV = 32;
    localparam logic [9:0] VEC [NV] = '{
        10'b00100_00110, // 0  R10 access from idle
        10'b01000_00110, // 1  R7 no ack mid access
        10'b01001_00000, // 2  R7 access ends
        10'b01000_10000, // 3  R7 ack at boundary
        10'b01100_10000, // 4  R7 held
        10'b01010_11000, // 5  R8 refresh due while released
        10'b01000_11000, // 6  R8
        10'b00100_00000, // 7  R7 bus returns
        10'b00100_00101, // 8  R9 refresh first
        10'b00101_00000, // 9  R9
        10'b00100_00110, // 10 R10
        10'b00001_00000, // 11 R10
        10'b10100_00000, // 12 R5 access-wait
        10'b11100_00000, // 13 R5 request refused
        10'b11010_00000, // 14 R6 tick under manual reset
        10'b11000_00101, // 15 R6 refresh runs
        10'b11001_00000, // 16 R6
        10'b11000_00000, // 17 R5
        10'b01000_00000, // 18 R5 leaves access-wait
        10'b01000_10000, // 19 R7
        10'b00000_00000, // 20 R7
        10'b00100_00110, // 21 R4 no new holdoff
        10'b10000_00110, // 22 R5 cycle continues
        10'b10001_00000, // 23 R5
        10'b10000_00000, // 24 R5
        10'b00100_00000, // 25 R4
        10'b00100_00110, // 26 R4
        10'b00001_00000, // 27 R4
        10'b01010_11000, // 28 R8
        10'b00000_00000, // 29 R7
        10'b01000_00101, // 30 R10 refresh over request
        10'b01001_00000  // 31 R10
    };

    function automatic string vtag(int i);
        case (i)
            0, 10, 11, 30, 31:                 return "R10";
            5, 6, 28:                          return "R8";
            8, 9:                              return "R9";
            12, 13, 17, 18, 22, 23, 24:        return "R5";
            14, 15, 16:                        return "R6";
            21, 25, 26, 27:                    return "R4";
            default:                           return "R7";
        endcase
    endfunction

    function automatic logic [4:0] outs();
        return {ext_ack, rfsh_out, bus_oe, acc_gnt, rfsh_go};
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(logic [4:0] v);
        {mrst, ext_req, acc_req, rfsh_tick, cyc_done} = v;
    endtask

    task automatic step(logic [4:0] v);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: finished %0d expected 1", finished);
            summary();
        end
    end

    initial begin
        #1 por_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 check("R1 reset state", outs(), 5'b0);

        // R2: holdoff of 127 edges after power-on
        @(negedge clk);
        acc_req = 1'b1;
        por_n = 1'b1;
        repeat (127) @(posedge clk);
        #1 check("R2 held off at edge 127", outs(), 5'b00000);
        @(posedge clk);
        #1 check("R2 granted at edge 128", outs(), 5'b00110);
        step(5'b00001);
        check("R2 access ends", outs(), 5'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][9:5]);
            check(vtag(i), outs(), VEC[i][4:0]);
        end

        // R3: long idle, counter stays saturated
        step(5'b00000);
        repeat (300) @(posedge clk);
        step(5'b00100);
        check("R3 grant after long idle", outs(), 5'b00110);

        // R1: power-on reset in mid access, no edge needed
        @(negedge clk);
        drive(5'b00000);
        #0.5 por_n = 1'b0;
        #0.5 check("R1 async quiet mid access", outs(), 5'b0);
        repeat (2) @(posedge clk);
        #1 check("R1 held quiet", outs(), 5'b0);
        @(negedge clk);
        por_n = 1'b1;
        step(5'b00000);
        check("R1 idle, no refresh pending", outs(), 5'b0);
        // counter was cleared again: held off at edge 2 after release
        step(5'b00100);
        check("R2 held off after new power-on", outs(), 5'b0);

        finished = 1'b1;
        summary();
    end
endmodule